// File: doc/BRIEF.md
# Downward-Growing Register Stack

This block is a last-in, first-out store built from a small register array and a stack pointer. The pointer starts one place past the bottom entry and moves toward lower indices as words are pushed. A push first lowers the pointer and then writes the input word at the new pointer. A pop reads the word at the pointer into an output register and then raises the pointer. Two flags tell the user when the array is completely used and when it holds nothing.

Requests that would overrun either end are refused. The pointer and the stored words stay as they are, and a one-cycle error pulse is raised. A cycle that carries both a push and a pop does nothing. The popped word appears on the data output one cycle after the pop strobe and holds until the next accepted pop.

Top module: `stk_lifo_top`

## Requirements
- R1: After reset the pointer reads DEPTH (11), the empty flag is 1, the full flag is 0, the error output is 0 and the data output is 0.
- R2: An accepted push (push high, pop low, full flag low) lowers the pointer by one in the next cycle and stores the input word at the new pointer index.
- R3: The full flag is 1 exactly when the pointer is 0. It rises with the push that brings the pointer to 0, and every accepted push clears the empty flag.
- R4: An accepted pop (pop high, push low, empty flag low) places the word stored at the current pointer on the data output in the next cycle and raises the pointer by one.
- R5: The empty flag is 1 exactly when the pointer equals DEPTH. Any accepted pop clears the full flag, and words come back in the reverse of their push order.
- R6: A push while full leaves the pointer, the flags and all stored words unchanged, and drives the error output to 1 in the next cycle.
- R7: A pop while empty leaves the pointer, the flags and the data output unchanged, and drives the error output to 1 in the next cycle.
- R8: A cycle with push and pop both high changes neither the pointer, the flags nor the stored words, and raises no error.
- R9: The error output stays high for one cycle for each refused strobe. The data output holds its last popped value in every cycle that has no accepted pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| din_i | input | WIDTH | Word to push |
| dout_o | output | WIDTH | Last popped word, registered |
| sp_o | output | $clog2(DEPTH+1) | Current stack pointer |
| full_o | output | 1 | Pointer is at 0 |
| empty_o | output | 1 | Pointer is at DEPTH |
| err_o | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
A pointer that is off by one shows up on sp_o one cycle after the push or pop that caused it. A flag that does not agree with the pointer is caught in the same cycle by comparing the two outputs. A write to the wrong entry stays hidden until that entry is popped, so the bench fills the array completely and drains it, and every index is read back. A refused request that still changes state is seen on the next cycle as a moved pointer, a changed data output or a missing error pulse.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_BLOCK = 2'd3
    } stk_op_e;

    // Decide what the stack does this cycle from the strobes and flags.
    function automatic stk_op_e stk_decode(input logic push,
                                           input logic pop,
                                           input logic full,
                                           input logic empty);
        stk_op_e op;
        op = OP_IDLE;
        if (push && !pop) begin
            op = full ? OP_BLOCK : OP_PUSH;
        end else if (pop && !push) begin
            op = empty ? OP_BLOCK : OP_POP;
        end
        return op;
    endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = 11,
    localparam int SPW  = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    output logic [SPW-1:0] sp,
    output logic           full,
    output logic           empty,
    output logic           err,
    output logic           wr_en,
    output logic [IW-1:0]  wr_idx,
    output logic           rd_en,
    output logic [IW-1:0]  rd_idx
);

    typedef struct packed {
        logic [SPW-1:0] sp;
        logic           full;
        logic           empty;
        logic           err;
    } ctrl_s;

    ctrl_s   s_d, s_q;
    stk_op_e op;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_idx  = IW'(s_q.sp - SPW'(1));
        rd_idx  = IW'(s_q.sp);
        op      = stk_decode(push, pop, s_q.full, s_q.empty);
        case (op)
            OP_PUSH: begin
                s_d.sp    = s_q.sp - SPW'(1);
                s_d.full  = (s_q.sp == SPW'(1));
                s_d.empty = 1'b0;
                wr_en     = 1'b1;
            end
            OP_POP: begin
                s_d.sp    = s_q.sp + SPW'(1);
                s_d.empty = (s_q.sp == SPW'(DEPTH - 1));
                s_d.full  = 1'b0;
                rd_en     = 1'b1;
            end
            OP_BLOCK: begin
                s_d.err = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sp    <= SPW'(DEPTH);
            s_q.full  <= 1'b0;
            s_q.empty <= 1'b1;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sp    = s_q.sp;
    assign full  = s_q.full;
    assign empty = s_q.empty;
    assign err   = s_q.err;

endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
    parameter int DEPTH = 11,
    parameter int WIDTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] dout_d, dout_q;
    logic [WIDTH-1:0] rd_word;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && (wr_idx == IW'(g))) begin
                mem_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_word = mem_q[i];
            end
        end
        dout_d = rd_en ? rd_word : dout_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign rd_data = dout_q;

endmodule

// File: rtl/stk_lifo_top.sv
module stk_lifo_top #(
    parameter int DEPTH = 11,
    parameter int WIDTH = 8,
    localparam int SPW  = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic [SPW-1:0]   sp_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);

    logic          wr_en, rd_en;
    logic [IW-1:0] wr_idx, rd_idx;

    stk_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push_i),
        .pop    (pop_i),
        .sp     (sp_o),
        .full   (full_o),
        .empty  (empty_o),
        .err    (err_o),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .rd_en  (rd_en),
        .rd_idx (rd_idx)
    );

    stk_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (din_i),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (dout_o)
    );

endmodule

// File: rtl/stk_lifo_chk.sv
module stk_lifo_chk #(
    parameter int DEPTH = 11,
    parameter int WIDTH = 8,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] din_i,
    input logic [WIDTH-1:0] dout_o,
    input logic [SPW-1:0]   sp_o,
    input logic             full_o,
    input logic             empty_o,
    input logic             err_o
);

    p_push_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (sp_o == SPW'($past(sp_o) - SPW'(1))));

    p_full_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_o == (sp_o == '0));

    p_pop_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (sp_o == SPW'($past(sp_o) + SPW'(1))));

    p_empty_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o == (sp_o == SPW'(DEPTH)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> ($stable(sp_o) && err_o));

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> ($stable(sp_o) && $stable(dout_o) && err_o));

    p_both_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> ($stable(sp_o) && !err_o));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i == pop_i) |=> !err_o);

    p_sp_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sp_o <= SPW'(DEPTH));

endmodule

bind stk_lifo_top stk_lifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .din_i   (din_i),
    .dout_o  (dout_o),
    .sp_o    (sp_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o)
);

// File: tb/stk_lifo_tb.sv
module stk_lifo_top_tb_top;

    localparam int DEPTH = 11;
    localparam int WIDTH = 8;
    localparam int SPW   = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] din_i = '0;
    logic [WIDTH-1:0] dout_o;
    logic [SPW-1:0]   sp_o;
    logic             full_o, empty_o, err_o;

    int checks = 0;
    int errors = 0;

    // Bench model of the stack, filled from the requirements.
    logic [WIDTH-1:0] m_mem [DEPTH];
    int               m_sp = DEPTH;
    logic [WIDTH-1:0] m_dout = '0;

    always #4 clk = ~clk;

    stk_lifo_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .din_i(din_i), .dout_o(dout_o), .sp_o(sp_o),
        .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one cycle of strobes, then sample at the following falling edge.
    task automatic step(input logic push, input logic pop, input logic [WIDTH-1:0] d);
        @(negedge clk);
        push_i = push; pop_i = pop; din_i = d;
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
    endtask

    task automatic chk_state(input string req, input int exp_err);
        chk({req, " sp"},    int'(sp_o),    m_sp);
        chk({req, " full"},  int'(full_o),  int'(m_sp == 0));
        chk({req, " empty"}, int'(empty_o), int'(m_sp == DEPTH));
        chk({req, " err"},   int'(err_o),   exp_err);
        chk({req, " dout"},  int'(dout_o),  int'(m_dout));
    endtask

    task automatic do_push(input string req, input logic [WIDTH-1:0] d);
        int exp_err;
        step(1'b1, 1'b0, d);
        exp_err = 0;
        if (m_sp == 0) exp_err = 1;
        else begin m_sp--; m_mem[m_sp] = d; end
        chk_state(req, exp_err);
    endtask

    task automatic do_pop(input string req);
        int exp_err;
        step(1'b0, 1'b1, '0);
        exp_err = 0;
        if (m_sp == DEPTH) exp_err = 1;
        else begin m_dout = m_mem[m_sp]; m_sp++; end
        chk_state(req, exp_err);
    endtask

    task automatic t_reset();
        chk_state("R1 reset", 0);
    endtask

    task automatic t_underflow();
        do_pop("R7 pop while empty");
        step(1'b0, 1'b0, '0);
        chk_state("R9 err drops after underflow", 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) begin
            do_push(i == DEPTH - 1 ? "R3 last push sets full" : "R2 push", WIDTH'(8'hA0 + i));
        end
    endtask

    task automatic t_overflow();
        do_push("R6 push while full", 8'h5A);
        do_push("R6 second push while full", 8'h5B);
        step(1'b0, 1'b0, '0);
        chk_state("R9 err one cycle after overflow", 0);
    endtask

    task automatic t_both();
        step(1'b1, 1'b1, 8'h77);
        chk_state("R8 push and pop together", 0);
    endtask

    task automatic t_drain();
        for (int i = 0; i < DEPTH; i++) begin
            do_pop(i == DEPTH - 1 ? "R5 last pop sets empty" : "R4 pop");
        end
        step(1'b0, 1'b0, '0);
        chk_state("R9 dout holds without pop", 0);
    endtask

    task automatic t_mixed();
        do_push("R2 mixed push", 8'h11);
        do_push("R2 mixed push", 8'h22);
        do_push("R2 mixed push", 8'h33);
        do_pop("R5 reverse order");
        do_push("R2 mixed push", 8'h44);
        step(1'b1, 1'b1, 8'h99);
        chk_state("R8 both while partly filled", 0);
        do_pop("R5 reverse order");
        do_pop("R5 reverse order");
        do_pop("R5 reverse order");
        do_pop("R7 pop after drain");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_underflow();
        t_fill();
        t_overflow();
        t_both();
        t_drain();
        t_mixed();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule